// File: doc/BRIEF.md
# Adaptive Filter Error Inner-Product Unit

This block is the forward half of a pipelined delayed-update adaptive FIR filter. On every clock it takes a vector of recent input samples and the matching vector of filter weights. It forms the filter output `y` as their inner product and then the error `e = d - y` against a desired sample `d`. A separate weight-adaptation stage uses the error. That stage is outside this block. The adaptation stage must allow for the fixed pipeline latency `PIPE_LATENCY` that the package exports.

Each sample is split into radix-4 digits. For every tap, a digit decoder selects 0, w, 2w or 3w through an AND/OR structure. The top digit is decoded as signed and selects 0, w, -2w or -w. Partial products with the same place value are summed across all taps first. There is one balanced binary tree per digit position. The column results are registered. A second balanced tree adds them after each one is shifted by its place value. Columns below a truncation point are never produced. A band of guard bits sits between the truncated columns and the output bits that are kept.

Top module: `dlms_err_unit`

## Requirements
- R1: Tap i occupies bits `[i*SAMP_W +: SAMP_W]` of `x_vec` and bits `[i*COEF_W +: COEF_W]` of `w_vec`, both two's complement. `y` is bits `[SUMW-1 : TRUNC+GUARD]` of the signed sum of all pruned partial-product terms (bits 17..10 with the defaults). An all-zero sample vector gives `y = 0`.
- R2: `e` is `OUT_W+1` bits wide and equals exactly the signed `d` minus the signed `y`. Both values come from the same input cycle.
- R3: Digit k of a sample is bits `[2k+1:2k]`. Lower digits are read as unsigned values 0..3. The most significant digit is read as signed (00=0, 01=1, 10=-2, 11=-1), so the sample is treated as two's complement.
- R4: For a digit k with `2k < TRUNC`, the term weight*digit*4^k is rounded down to a multiple of 2^TRUNC before it is summed. Bits below 2^TRUNC are never formed.
- R5: Inputs present before clock edge n appear on `y` and `e` after edge n+1 (latency 2). A new result comes out every cycle with back-to-back inputs.
- R6: A clock edge with `rst` high forces `y` and `e` to zero. They also stay zero after the first edge following release, because the cleared pipeline stage is still draining.
- R7: All-zero weights give `y = 0` and `e = d`, whatever the samples are.
- R8: The most negative operands do not wrap. Every sample and weight at -128 gives `y = 64`. Every sample at -128 with every weight at 127 gives `y = -64`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| x_vec | input | TAPS*SAMP_W | Delay-line samples, tap 0 in the low bits |
| w_vec | input | TAPS*COEF_W | Filter weights, same packing as the samples |
| d | input | OUT_W | Desired sample, two's complement |
| y | output | OUT_W | Filter output, registered |
| e | output | OUT_W+1 | Error d - y, registered |

## Verification
The bench builds the block with four taps, 8-bit samples and weights, six truncated columns and four guard bits. With these values the full sum is 18 bits wide and the kept output is 8 bits. Three of the four digit positions are pruned by different amounts (6, 4 and 2 columns), and the signed top digit is left whole. This makes it possible to choose vectors where pruning moves `y` across a boundary of the output's least significant bit. It also brings the -2w selection and the largest-magnitude sums within reach, where a wrap in the column or shift-add trees would be visible.

// File: rtl/dlms_err_pkg.sv
package dlms_err_pkg;

    // cycles from input sample to registered y and e
    localparam int PIPE_LATENCY = 2;

    localparam int DEF_TAPS   = 4;
    localparam int DEF_SAMP_W = 8;
    localparam int DEF_COEF_W = 8;
    localparam int DEF_TRUNC  = 6;
    localparam int DEF_GUARD  = 4;

    // place value of radix-4 digit k, as a left shift
    function automatic int digit_shift(input int k);
        return 2 * k;
    endfunction

endpackage

// File: rtl/dlms_err_ppg.sv
module dlms_err_ppg
    import dlms_err_pkg::*;
#(
    parameter int SAMP_W = DEF_SAMP_W,
    parameter int COEF_W = DEF_COEF_W,
    parameter int TRUNC  = DEF_TRUNC
) (
    input  logic [SAMP_W-1:0]                   samp,
    input  logic [COEF_W-1:0]                   coef,
    output logic [(SAMP_W/2)*(COEF_W+2)-1:0]    pp_flat
);
    localparam int DIGITS = SAMP_W / 2;
    localparam int PPW    = COEF_W + 2;

    logic signed [PPW-1:0] one_w, two_w, three_w, neg_one_w, neg_two_w;

    assign one_w     = {{2{coef[COEF_W-1]}}, coef};
    assign two_w     = {coef[COEF_W-1], coef, 1'b0};
    assign three_w   = one_w + two_w;
    assign neg_one_w = -one_w;
    assign neg_two_w = -two_w;

    for (genvar k = 0; k < DIGITS; k++) begin : g_digit
        localparam int CUT_RAW = TRUNC - digit_shift(k);
        localparam int CUT     = (CUT_RAW < 0) ? 0 : CUT_RAW;
        localparam logic [PPW-1:0] KEEP = {PPW{1'b1}} << CUT;

        logic       sel1, sel2, sel3;
        logic [PPW-1:0] picked;

        // 2-to-3 decode: at most one select line is high
        assign sel1 =  samp[2*k] & ~samp[2*k+1];
        assign sel2 = ~samp[2*k] &  samp[2*k+1];
        assign sel3 =  samp[2*k] &  samp[2*k+1];

        if (k == DIGITS - 1) begin : g_top
            // signed top digit: 1, -2, -1
            assign picked = ({PPW{sel1}} & one_w)
                          | ({PPW{sel2}} & neg_two_w)
                          | ({PPW{sel3}} & neg_one_w);
        end else begin : g_low
            assign picked = ({PPW{sel1}} & one_w)
                          | ({PPW{sel2}} & two_w)
                          | ({PPW{sel3}} & three_w);
        end

        // columns under the truncation point are never produced
        assign pp_flat[k*PPW +: PPW] = picked & KEEP;
    end

endmodule

// File: rtl/dlms_err_sum_tree.sv
module dlms_err_sum_tree #(
    parameter int COUNT = 4,
    parameter int IN_W  = 10,
    parameter int OUT_W = 12
) (
    input  logic [COUNT*IN_W-1:0]  terms,
    output logic signed [OUT_W-1:0] total
);
    // heap layout: leaves at COUNT-1 .. 2*COUNT-2, root at 0;
    // a power-of-two COUNT gives log2(COUNT) adder stages
    logic signed [OUT_W-1:0] node [0:2*COUNT-2];

    for (genvar i = 0; i < COUNT; i++) begin : g_leaf
        assign node[COUNT-1+i] = OUT_W'($signed(terms[i*IN_W +: IN_W]));
    end

    for (genvar j = 0; j < COUNT - 1; j++) begin : g_add
        assign node[j] = node[2*j+1] + node[2*j+2];
    end

    assign total = node[0];

endmodule

// File: rtl/dlms_err_unit.sv
module dlms_err_unit
    import dlms_err_pkg::*;
#(
    parameter int TAPS   = DEF_TAPS,
    parameter int SAMP_W = DEF_SAMP_W,
    parameter int COEF_W = DEF_COEF_W,
    parameter int TRUNC  = DEF_TRUNC,
    parameter int GUARD  = DEF_GUARD,
    localparam int SUMW  = COEF_W + SAMP_W + $clog2(TAPS),
    localparam int OUT_W = SUMW - TRUNC - GUARD
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [TAPS*SAMP_W-1:0]   x_vec,
    input  logic [TAPS*COEF_W-1:0]   w_vec,
    input  logic [OUT_W-1:0]         d,
    output logic [OUT_W-1:0]         y,
    output logic [OUT_W:0]           e
);
    localparam int DIGITS = SAMP_W / 2;
    localparam int PPW    = COEF_W + 2;
    localparam int LGN    = $clog2(TAPS);
    localparam int COLW   = PPW + LGN;
    localparam int LOWB   = TRUNC + GUARD;

    // ---------------- partial products, one generator per tap
    logic [TAPS*DIGITS*PPW-1:0] pp_all;

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        dlms_err_ppg #(
            .SAMP_W (SAMP_W),
            .COEF_W (COEF_W),
            .TRUNC  (TRUNC)
        ) u_ppg (
            .samp    (x_vec[t*SAMP_W +: SAMP_W]),
            .coef    (w_vec[t*COEF_W +: COEF_W]),
            .pp_flat (pp_all[t*DIGITS*PPW +: DIGITS*PPW])
        );
    end

    // ---------------- column trees: same place value across taps
    logic signed [COLW-1:0] col_q [DIGITS];
    logic [DIGITS*SUMW-1:0] shifted;

    for (genvar k = 0; k < DIGITS; k++) begin : g_col
        logic [TAPS*PPW-1:0]    col_in;
        logic signed [COLW-1:0] col_sum;

        for (genvar t = 0; t < TAPS; t++) begin : g_gather
            assign col_in[t*PPW +: PPW] = pp_all[(t*DIGITS + k)*PPW +: PPW];
        end

        dlms_err_sum_tree #(
            .COUNT (TAPS),
            .IN_W  (PPW),
            .OUT_W (COLW)
        ) u_col_tree (
            .terms (col_in),
            .total (col_sum)
        );

        always_ff @(posedge clk) begin
            if (rst) col_q[k] <= '0;
            else     col_q[k] <= col_sum;
        end

        assign shifted[k*SUMW +: SUMW] = SUMW'(col_q[k]) <<< digit_shift(k);
    end

    // desired sample follows the column stage
    logic [OUT_W-1:0] d_q;

    always_ff @(posedge clk) begin
        if (rst) d_q <= '0;
        else     d_q <= d;
    end

    // ---------------- shift-add tree across place values
    logic signed [SUMW-1:0] full_sum;
    logic [OUT_W-1:0]       y_next;
    logic [LOWB-1:0]        guard_bits_unused;

    dlms_err_sum_tree #(
        .COUNT (DIGITS),
        .IN_W  (SUMW),
        .OUT_W (SUMW)
    ) u_shift_add (
        .terms (shifted),
        .total (full_sum)
    );

    assign y_next            = full_sum[SUMW-1 -: OUT_W];
    assign guard_bits_unused = full_sum[LOWB-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            y <= '0;
            e <= '0;
        end else begin
            y <= y_next;
            e <= {d_q[OUT_W-1], d_q} - {y_next[OUT_W-1], y_next};
        end
    end

    // ---------------- checks
    logic [1:0] warm_q;

    always_ff @(posedge clk) begin
        if (rst)                warm_q <= '0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    p_reset_zero_r6: assert property (@(posedge clk)
        rst |=> (y == '0 && e == '0));

    p_err_diff_r2: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |->
            (int'($signed(e)) == int'($signed($past(d, 2))) - int'($signed(y))));

    p_zero_coef_r7: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2 && $past(w_vec, 2) == '0) |->
            (y == '0 && int'($signed(e)) == int'($signed($past(d, 2)))));

    p_zero_samp_r1: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2 && $past(x_vec, 2) == '0) |-> (y == '0));

endmodule

// File: tb/dlms_err_unit_bench.sv
`timescale 1ns/1ps
module dlms_err_unit_bench;

    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] xv = '0;
    logic [31:0] wv = '0;
    logic [7:0]  dv = '0;
    logic [7:0]  y;
    logic [8:0]  e;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    dlms_err_unit u_dlms_err_unit (
        .clk   (clk),
        .rst   (rst),
        .x_vec (xv),
        .w_vec (wv),
        .d     (dv),
        .y     (y),
        .e     (e)
    );

    // {samples, weights, desired}
    localparam logic [71:0] VEC [0:NV-1] = '{
        {32'h01020304, 32'h01010101, 8'h00},
        {32'h7F7F7F7F, 32'h7F7F7F7F, 8'h10},
        {32'h80808080, 32'h80808080, 8'h00},
        {32'hFFFFFFFF, 32'h7F807F80, 8'h05},
        {32'h12345678, 32'h9ABCDEF0, 8'h7F},
        {32'hC3A55A3C, 32'h0F1E2D3C, 8'h80},
        {32'h00000000, 32'hFFFFFFFF, 8'h33},
        {32'h55AA55AA, 32'h00000000, 8'hC8}
    };

    // sum of pruned terms as stated in R1, R3, R4
    function automatic longint model_acc(input logic [31:0] xs, input logic [31:0] ws);
        longint acc, wi, dg, term;
        acc = 0;
        for (int t = 0; t < 4; t++) begin
            wi = longint'($signed(ws[t*8 +: 8]));
            for (int k = 0; k < 4; k++) begin
                dg = longint'(xs[t*8 + 2*k +: 2]);
                if (k == 3 && dg >= 2) dg = dg - 4;
                term = wi * dg * (longint'(1) << (2*k));
                if (2*k < 6) term = (term >>> 6) <<< 6;
                acc += term;
            end
        end
        return acc;
    endfunction

    function automatic logic [7:0] model_y(input logic [31:0] xs, input logic [31:0] ws);
        return 8'(model_acc(xs, ws) >>> 10);
    endfunction

    function automatic logic [8:0] model_e(input logic [7:0] dd, input logic [7:0] yy);
        return 9'(int'($signed(dd)) - int'($signed(yy)));
    endfunction

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
        end
    endtask

    task automatic run_one(input logic [31:0] xs, input logic [31:0] ws, input logic [7:0] dd);
        @(negedge clk);
        xv = xs; wv = ws; dv = dd;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] tx, tw;
        logic [7:0]  td, ty;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R6 reset y", {y[7], y}, 9'd0);
        chk("R6 reset e", e, 9'd0);
        rst = 1'b0;

        // streaming table, one vector per cycle, results two edges later (R5)
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                {tx, tw, td} = VEC[i-2];
                ty = model_y(tx, tw);
                chk("R1 R5 stream y", {y[7], y}, {ty[7], ty});
                chk("R2 R5 stream e", e, model_e(td, ty));
            end
            if (i < NV) {xv, wv, dv} = VEC[i];
        end

        // R8 extreme operands
        run_one(32'h80808080, 32'h80808080, 8'h00);
        chk("R8 max positive y", {y[7], y}, 9'd64);
        chk("R8 max positive e", e, 9'h1C0);
        run_one(32'h80808080, 32'h7F7F7F7F, 8'h00);
        chk("R8 max negative y", {y[7], y}, 9'h1C0);
        chk("R8 max negative e", e, 9'd64);

        // R7 zero weights
        run_one(32'h12345678, 32'h00000000, 8'h9C);
        chk("R7 zero weight y", {y[7], y}, 9'd0);
        chk("R7 zero weight e", e, 9'h19C);

        // R4 pruning pulls the sum below one output step (exact would give 1)
        run_one(32'h00030303, 32'h007F7F7F, 8'h00);
        chk("R4 pruned y", {y[7], y}, 9'd0);
        chk("R4 pruned e", e, 9'd0);

        // R3 signed top digit: 11 reads as -1
        run_one(32'h000000C0, 32'h00000040, 8'h00);
        chk("R3 top digit y", {y[7], y}, 9'h1FC);
        chk("R3 top digit e", e, 9'd4);

        // R6 reset in mid-run with live inputs
        run_one(VEC[1][71:40], VEC[1][39:8], VEC[1][7:0]);
        ty = model_y(VEC[1][71:40], VEC[1][39:8]);
        chk("R1 before reset y", {y[7], y}, {ty[7], ty});
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R6 during reset y", {y[7], y}, 9'd0);
        chk("R6 during reset e", e, 9'd0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R6 draining y", {y[7], y}, 9'd0);
        chk("R6 draining e", e, 9'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R5 after release y", {y[7], y}, {ty[7], ty});
        chk("R2 after release e", e, model_e(VEC[1][7:0], ty));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule